// File: doc/BRIEF.md
# Debug Comparator Match Qualifier

This block decides which of a small bank of hardware breakpoint or watchpoint comparators really fires in the current execution context. Each comparator already has an address-hit flag computed elsewhere. The block takes that flag together with the comparator's control word. It then keeps or discards the hit based on four things: the current security state, the effective privilege level, an optional link to a context-ID comparator, and a global debug gate.

All comparators are judged in parallel. A priority encoder then reports one any-match flag and the index of the lowest comparator that fired. Both results are registered, so a decision is visible one clock after its inputs.

The control word is laid out as follows:
- bits [2:1]: two privilege-access enables.
- bit [13]: higher-level enable.
- bits [15:14]: security filter.
- bits [19:16]: linked comparator number.
- bit [20]: link enable.

A linked context comparator uses its own control word, in which bit [0] is enable and bits [23:20] are the type. Its value register is 64 bits wide, and only the low 32 bits are compared.

Top module: `dbg_match_unit`

## Requirements
- R1: While reset is asserted and on the first edge after it, match_any is 0 and match_idx is 0.
- R2: The security filter works as follows. Value 0 passes in both states. Values 1 and 3 discard a hit while secure is 1. Value 2 discards a hit while secure is 0.
- R3: The privilege filter depends on the effective level. At level 0, control bit [2] must be set. At level 1, control bit [1] must be set. At levels 2 and 3, control bit [13] must be set. Otherwise the hit is discarded.
- R4: In watchpoint mode (watch_mode=1) with unpriv_access=1, the privilege filter uses level 0 whatever cur_level is. In breakpoint mode, unpriv_access has no effect.
- R5: A comparator whose cmp_hit bit is 0 never fires.
- R6: With link enable set, the link fails when the linked number is above LAST_BP_IDX (default 3). It also fails when the number is below LAST_BP_IDX-CTX_CAP (default 1).
- R7: With link enable set, the link fails when bit [0] of the linked control word is 0.
- R8: With link enable set, the link passes only when three things hold: the linked type [23:20] equals 3, cur_level is at most 1, and ctx_id equals the low 32 bits of the linked value register. Any other type never passes.
- R9: When dbg_global_en is 0 or dbg_exc_ok is 0, no comparator fires.
- R10: When several comparators fire, match_idx is the lowest firing index. When none fires, match_idx is 0.
- R11: match_any and match_idx reflect the inputs sampled at the previous rising clock edge.
- R12: With link enable clear, the linked number and the link bank have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| watch_mode | input | 1 | 1: the bank holds watchpoints, 0: breakpoints |
| dbg_global_en | input | 1 | Global monitor-debug enable |
| dbg_exc_ok | input | 1 | Debug exceptions may be taken now |
| cur_level | input | 2 | Current privilege level 0..3 |
| secure | input | 1 | Current security state |
| unpriv_access | input | 1 | Access is marked unprivileged |
| ctx_id | input | 32 | Current context ID |
| cmp_hit | input | NUM_CMP | Per-comparator address hit |
| cmp_ctrl | input | NUM_CMP*32 | Per-comparator control words |
| link_ctrl | input | (LAST_BP_IDX+1)*32 | Control words of the linkable comparators |
| link_value | input | (LAST_BP_IDX+1)*64 | Value registers of the linkable comparators |
| match_any | output | 1 | Some comparator fired (registered) |
| match_idx | output | $clog2(NUM_CMP) | Lowest firing comparator (registered) |

## Verification
Every result sits behind exactly one register stage. The value for a given input set is therefore due on the first rising edge after the inputs are applied, and not earlier.

The bench changes inputs only at falling edges. It waits for one rising edge and reads the outputs at the following falling edge.

For latency, the bench also reads the outputs at the falling edge where new inputs are applied. At that point they must still show the earlier decision.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;
    localparam int CTRL_W     = 32;
    localparam int PAC_LO     = 1;
    localparam int HMC_BIT    = 13;
    localparam int SSC_LO     = 14;
    localparam int LBN_LO     = 16;
    localparam int LBN_W      = 4;
    localparam int LINK_BIT   = 20;
    localparam int LEN_BIT    = 0;
    localparam int LTYPE_LO   = 20;
    localparam int LTYPE_W    = 4;
    localparam logic [LTYPE_W-1:0] LTYPE_CTX = 4'd3;

    typedef enum logic [1:0] {
        SEC_EITHER = 2'd0,
        SEC_NS_A   = 2'd1,
        SEC_ONLY   = 2'd2,
        SEC_NS_B   = 2'd3
    } sec_filter_e;
endpackage

// File: rtl/dbg_link_check.sv
module dbg_link_check
    import dbg_match_pkg::*;
#(
    parameter int LAST_BP_IDX = 3,
    parameter int CTX_CAP     = 2,
    parameter int CTX_W       = 32,
    parameter int VAL_W       = 64,
    localparam int SLOTS      = LAST_BP_IDX + 1
) (
    input  logic [LBN_W-1:0]        lbn,
    input  logic [SLOTS*CTRL_W-1:0] link_ctrl,
    input  logic [SLOTS*VAL_W-1:0]  link_value,
    input  logic [1:0]              cur_level,
    input  logic [CTX_W-1:0]        ctx_id,
    output logic                    link_ok
);
    logic              in_range;
    logic [CTRL_W-1:0] sel_ctrl;
    logic [VAL_W-1:0]  sel_val;

    always_comb begin
        in_range = (int'(lbn) <= LAST_BP_IDX) && (int'(lbn) >= LAST_BP_IDX - CTX_CAP);
        sel_ctrl = '0;
        sel_val  = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (int'(lbn) == s) begin
                sel_ctrl = link_ctrl[s*CTRL_W +: CTRL_W];
                sel_val  = link_value[s*VAL_W +: VAL_W];
            end
        end
        link_ok = in_range
                  && sel_ctrl[LEN_BIT]
                  && (sel_ctrl[LTYPE_LO +: LTYPE_W] == LTYPE_CTX)
                  && (cur_level <= 2'd1)
                  && (sel_val[CTX_W-1:0] == ctx_id);
    end

    always_comb begin
        if (cur_level > 2'd1) begin
            assert_link_level_R8: assert (!link_ok)
                else $error("context link passed above level 1");
        end
        if (int'(lbn) > LAST_BP_IDX) begin
            assert_link_range_R6: assert (!link_ok)
                else $error("context link passed out of range");
        end
    end
endmodule

// File: rtl/dbg_cmp_filter.sv
module dbg_cmp_filter
    import dbg_match_pkg::*;
(
    input  logic              hit,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [1:0]        eff_level,
    input  logic              secure,
    input  logic              link_ok,
    output logic              fire
);
    logic        sec_ok;
    logic        lvl_ok;
    logic [1:0]  pac;
    sec_filter_e ssc;

    always_comb begin
        pac = ctrl[PAC_LO +: 2];
        ssc = sec_filter_e'(ctrl[SSC_LO +: 2]);
        unique case (ssc)
            SEC_EITHER:         sec_ok = 1'b1;
            SEC_ONLY:           sec_ok = secure;
            SEC_NS_A, SEC_NS_B: sec_ok = !secure;
            default:            sec_ok = 1'b0;
        endcase
        unique case (eff_level)
            2'd0:    lvl_ok = pac[1];
            2'd1:    lvl_ok = pac[0];
            default: lvl_ok = ctrl[HMC_BIT];
        endcase
        fire = hit && sec_ok && lvl_ok && (!ctrl[LINK_BIT] || link_ok);
    end

    always_comb begin
        if (secure && (ctrl[SSC_LO] == 1'b1)) begin
            assert_sec_reject_R2: assert (!fire)
                else $error("secure hit passed a non-secure filter");
        end
        if (!hit) begin
            assert_no_hit_R5: assert (!fire)
                else $error("fire without hit");
        end
    end
endmodule

// File: rtl/dbg_prio_pick.sv
module dbg_prio_pick #(
    parameter int N      = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    always_comb begin
        if (any) begin
            assert_pick_valid_R10: assert (req[idx])
                else $error("picked index has no request");
        end
    end
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
    import dbg_match_pkg::*;
#(
    parameter int NUM_CMP     = 4,
    parameter int LAST_BP_IDX = 3,
    parameter int CTX_CAP     = 2,
    parameter int CTX_W       = 32,
    parameter int VAL_W       = 64,
    localparam int SLOTS      = LAST_BP_IDX + 1,
    localparam int IDX_W      = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      watch_mode,
    input  logic                      dbg_global_en,
    input  logic                      dbg_exc_ok,
    input  logic [1:0]                cur_level,
    input  logic                      secure,
    input  logic                      unpriv_access,
    input  logic [CTX_W-1:0]          ctx_id,
    input  logic [NUM_CMP-1:0]        cmp_hit,
    input  logic [NUM_CMP*CTRL_W-1:0] cmp_ctrl,
    input  logic [SLOTS*CTRL_W-1:0]   link_ctrl,
    input  logic [SLOTS*VAL_W-1:0]    link_value,
    output logic                      match_any,
    output logic [IDX_W-1:0]          match_idx
);
    typedef struct packed {
        logic             any;
        logic [IDX_W-1:0] idx;
    } match_st_t;

    match_st_t          st_d, st_q;
    logic [1:0]         eff_level;
    logic [NUM_CMP-1:0] fire_raw;
    logic [NUM_CMP-1:0] link_ok;
    logic [NUM_CMP-1:0] fire_gated;
    logic               pick_any;
    logic [IDX_W-1:0]   pick_idx;

    assign eff_level = (watch_mode && unpriv_access) ? 2'd0 : cur_level;

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
        dbg_link_check #(
            .LAST_BP_IDX (LAST_BP_IDX),
            .CTX_CAP     (CTX_CAP),
            .CTX_W       (CTX_W),
            .VAL_W       (VAL_W)
        ) u_link (
            .lbn        (cmp_ctrl[c*CTRL_W + LBN_LO +: LBN_W]),
            .link_ctrl  (link_ctrl),
            .link_value (link_value),
            .cur_level  (cur_level),
            .ctx_id     (ctx_id),
            .link_ok    (link_ok[c])
        );
        dbg_cmp_filter u_filt (
            .hit       (cmp_hit[c]),
            .ctrl      (cmp_ctrl[c*CTRL_W +: CTRL_W]),
            .eff_level (eff_level),
            .secure    (secure),
            .link_ok   (link_ok[c]),
            .fire      (fire_raw[c])
        );
    end

    assign fire_gated = (dbg_global_en && dbg_exc_ok) ? fire_raw : '0;

    dbg_prio_pick #(.N(NUM_CMP)) u_pick (
        .req (fire_gated),
        .any (pick_any),
        .idx (pick_idx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.any = pick_any;
        st_d.idx = pick_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign match_any = st_q.any;
    assign match_idx = st_q.idx;

    property p_gate_off;
        @(posedge clk) disable iff (!rst_n)
            !(dbg_global_en && dbg_exc_ok) |=> !match_any;
    endproperty
    assert_gate_off_R9: assert property (p_gate_off)
        else $error("match while debug gated off");

    property p_no_hits;
        @(posedge clk) disable iff (!rst_n)
            (cmp_hit == '0) |=> !match_any;
    endproperty
    assert_no_hits_R5: assert property (p_no_hits)
        else $error("match with no hit inputs");

    property p_idle_idx;
        @(posedge clk) disable iff (!rst_n)
            !match_any |-> (match_idx == '0);
    endproperty
    assert_idle_idx_R10: assert property (p_idle_idx)
        else $error("nonzero index without match");

    property p_latency;
        @(posedge clk) disable iff (!rst_n)
            (cmp_hit[0] && dbg_global_en && dbg_exc_ok && cmp_ctrl[SSC_LO +: 2] == 2'd0
             && !cmp_ctrl[LINK_BIT] && cmp_ctrl[PAC_LO +: 2] == 2'b11 && cmp_ctrl[HMC_BIT])
            |=> (match_any && match_idx == '0);
    endproperty
    assert_latency_R11: assert property (p_latency)
        else $error("open comparator 0 not reported next cycle");
endmodule

// File: tb/sim_dbg_match_unit.sv
module sim_dbg_match_unit;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 4;
    localparam int SL  = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          watch_mode, dbg_global_en, dbg_exc_ok, secure, unpriv_access;
    logic [1:0]    cur_level;
    logic [31:0]   ctx_id;
    logic [N-1:0]  cmp_hit;
    logic [N*32-1:0]  cmp_ctrl;
    logic [SL*32-1:0] link_ctrl;
    logic [SL*64-1:0] link_value;
    logic          match_any;
    logic [1:0]    match_idx;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_match_unit u0 (
        .clk(clk), .rst_n(rst_n), .watch_mode(watch_mode),
        .dbg_global_en(dbg_global_en), .dbg_exc_ok(dbg_exc_ok),
        .cur_level(cur_level), .secure(secure), .unpriv_access(unpriv_access),
        .ctx_id(ctx_id), .cmp_hit(cmp_hit), .cmp_ctrl(cmp_ctrl),
        .link_ctrl(link_ctrl), .link_value(link_value),
        .match_any(match_any), .match_idx(match_idx)
    );

    function automatic logic [31:0] mk_ctrl(logic [1:0] pac, logic hmc, logic [1:0] ssc,
                                             logic [3:0] lbn, logic linked);
        logic [31:0] w = '0;
        w[2:1] = pac; w[13] = hmc; w[15:14] = ssc; w[19:16] = lbn; w[20] = linked;
        return w;
    endfunction

    function automatic logic [31:0] mk_link(logic en, logic [3:0] ty);
        logic [31:0] w = '0;
        w[0] = en; w[23:20] = ty;
        return w;
    endfunction

    task automatic compare(logic exp_any, logic [1:0] exp_idx, string tag);
        checks++;
        if (match_any !== exp_any || match_idx !== exp_idx) begin
            errors++;
            $display("FAIL %s: got any=%0b idx=%0d, expected any=%0b idx=%0d",
                     tag, match_any, match_idx, exp_any, exp_idx);
        end
    endtask

    task automatic step_check(logic exp_any, logic [1:0] exp_idx, string tag);
        @(posedge clk);
        @(negedge clk);
        compare(exp_any, exp_idx, tag);
    endtask

    task automatic defaults();
        watch_mode = 0; dbg_global_en = 1; dbg_exc_ok = 1; secure = 0;
        unpriv_access = 0; cur_level = 2'd1; ctx_id = 32'h1234_5678; cmp_hit = '0;
        for (int i = 0; i < N; i++) cmp_ctrl[i*32 +: 32] = mk_ctrl(2'b11, 1'b1, 2'd0, 4'd0, 1'b0);
        link_ctrl = '0; link_value = '0;
    endtask

    task automatic t_reset();
        defaults();
        cmp_hit = 4'b1111;
        rst_n = 0;
        repeat (3) @(negedge clk);
        compare(0, 0, "R1 during reset");
        cmp_hit = '0;
        rst_n = 1;
        step_check(0, 0, "R1 after reset");
    endtask

    task automatic t_basic_latency();
        defaults();
        cmp_hit = 4'b0100;
        compare(0, 0, "R11 not before edge");
        step_check(1, 2, "R11 one cycle later");
        cmp_hit = 4'b0000;
        step_check(0, 0, "R5 no hits");
    endtask

    task automatic t_priority();
        defaults();
        cmp_hit = 4'b1010; step_check(1, 1, "R10 lowest of 1,3");
        cmp_hit = 4'b1100; step_check(1, 2, "R10 lowest of 2,3");
        cmp_hit = 4'b1111; step_check(1, 0, "R10 all");
        cmp_ctrl[0 +: 32] = mk_ctrl(2'b00, 1'b0, 2'd0, 4'd0, 1'b0);
        cmp_hit = 4'b1001; step_check(1, 3, "R10 blocked 0 falls to 3");
    endtask

    task automatic t_security();
        defaults();
        cmp_hit = 4'b0001;
        secure = 1;
        cmp_ctrl[0 +: 32] = mk_ctrl(2'b11, 1, 2'd1, 0, 0); step_check(0, 0, "R2 ssc1 secure");
        cmp_ctrl[0 +: 32] = mk_ctrl(2'b11, 1, 2'd3, 0, 0); step_check(0, 0, "R2 ssc3 secure");
        cmp_ctrl[0 +: 32] = mk_ctrl(2'b11, 1, 2'd2, 0, 0); step_check(1, 0, "R2 ssc2 secure");
        cmp_ctrl[0 +: 32] = mk_ctrl(2'b11, 1, 2'd0, 0, 0); step_check(1, 0, "R2 ssc0 secure");
        secure = 0;
        cmp_ctrl[0 +: 32] = mk_ctrl(2'b11, 1, 2'd2, 0, 0); step_check(0, 0, "R2 ssc2 nonsecure");
        cmp_ctrl[0 +: 32] = mk_ctrl(2'b11, 1, 2'd1, 0, 0); step_check(1, 0, "R2 ssc1 nonsecure");
    endtask

    task automatic t_level();
        defaults();
        cmp_hit = 4'b0001;
        cmp_ctrl[0 +: 32] = mk_ctrl(2'b01, 0, 0, 0, 0);
        cur_level = 1; step_check(1, 0, "R3 L1 pac0");
        cur_level = 0; step_check(0, 0, "R3 L0 pac0 only");
        cur_level = 2; step_check(0, 0, "R3 L2 no hmc");
        cmp_ctrl[0 +: 32] = mk_ctrl(2'b10, 0, 0, 0, 0);
        cur_level = 0; step_check(1, 0, "R3 L0 pac1");
        cur_level = 1; step_check(0, 0, "R3 L1 pac1 only");
        cmp_ctrl[0 +: 32] = mk_ctrl(2'b00, 1, 0, 0, 0);
        cur_level = 3; step_check(1, 0, "R3 L3 hmc");
        cur_level = 2; step_check(1, 0, "R3 L2 hmc");
    endtask

    task automatic t_unpriv();
        defaults();
        cmp_hit = 4'b0001;
        cur_level = 1; unpriv_access = 1; watch_mode = 1;
        cmp_ctrl[0 +: 32] = mk_ctrl(2'b01, 0, 0, 0, 0); step_check(0, 0, "R4 watch unpriv pac0");
        cmp_ctrl[0 +: 32] = mk_ctrl(2'b10, 0, 0, 0, 0); step_check(1, 0, "R4 watch unpriv pac1");
        cur_level = 3;                                    step_check(1, 0, "R4 watch unpriv from L3");
        cur_level = 1; watch_mode = 0;
        cmp_ctrl[0 +: 32] = mk_ctrl(2'b01, 0, 0, 0, 0); step_check(1, 0, "R4 break ignores unpriv");
    endtask

    task automatic t_gate();
        defaults();
        cmp_hit = 4'b0110;
        dbg_global_en = 0; step_check(0, 0, "R9 global off");
        dbg_global_en = 1; dbg_exc_ok = 0; step_check(0, 0, "R9 exc not allowed");
        dbg_exc_ok = 1; step_check(1, 1, "R9 restored");
    endtask

    task automatic t_link();
        defaults();
        cmp_hit = 4'b0001;
        for (int s = 0; s < SL; s++) begin
            link_ctrl[s*32 +: 32]  = mk_link(1'b1, 4'd3);
            link_value[s*64 +: 64] = {32'hDEAD_BEEF, 32'h1234_5678};
        end
        cmp_ctrl[0 +: 32] = mk_ctrl(2'b11, 1, 0, 4'd2, 1);
        step_check(1, 0, "R8 ctx match high bits ignored");
        ctx_id = 32'h1234_5679; step_check(0, 0, "R8 ctx mismatch");
        ctx_id = 32'h1234_5678; cur_level = 2; step_check(0, 0, "R8 level above 1");
        cur_level = 0; step_check(1, 0, "R8 level 0");
        cur_level = 1;
        link_ctrl[2*32 +: 32] = mk_link(1'b1, 4'd5); step_check(0, 0, "R8 type 5");
        link_ctrl[2*32 +: 32] = mk_link(1'b1, 4'd11); step_check(0, 0, "R8 type 11");
        link_ctrl[2*32 +: 32] = mk_link(1'b0, 4'd3); step_check(0, 0, "R7 link disabled");
        link_ctrl[2*32 +: 32] = mk_link(1'b1, 4'd3);
        cmp_ctrl[0 +: 32] = mk_ctrl(2'b11, 1, 0, 4'd0, 1); step_check(0, 0, "R6 below range");
        cmp_ctrl[0 +: 32] = mk_ctrl(2'b11, 1, 0, 4'd1, 1); step_check(1, 0, "R6 low edge");
        cmp_ctrl[0 +: 32] = mk_ctrl(2'b11, 1, 0, 4'd3, 1); step_check(1, 0, "R6 top edge");
        cmp_ctrl[0 +: 32] = mk_ctrl(2'b11, 1, 0, 4'd5, 1); step_check(0, 0, "R6 above range");
        cmp_ctrl[0 +: 32] = mk_ctrl(2'b11, 1, 0, 4'd5, 0); step_check(1, 0, "R12 unlinked bad lbn");
        link_ctrl = '0; ctx_id = 32'h0;
        cmp_ctrl[0 +: 32] = mk_ctrl(2'b11, 1, 0, 4'd0, 0); step_check(1, 0, "R12 unlinked empty bank");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_basic_latency();
        t_priority();
        t_security();
        t_level();
        t_unpriv();
        t_gate();
        t_link();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule